// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides an unsigned numerator by an unsigned denominator of the same width, WIDTH bits. It works one quotient bit at a time with a compare, subtract and shift loop. A one-cycle `start` pulse, accepted while `ready` is high, captures both operands. The machine then clears its partial remainder, loads the numerator into the quotient shift register and runs WIDTH+1 iterations. `ready` returns high when the last iteration ends. `quotient` and `remainder` then stay valid until the next accepted start.

Each iteration takes two cycles. When the partial remainder is at least the denominator, the machine goes through SUBTRACT and then SHIFT1. SHIFT1 shifts the remainder left, takes in the quotient's top bit, and shifts a 1 into the quotient. When the partial remainder is smaller, the machine goes through NOP and then SHIFT0. NOP is an idle cycle that makes this branch as long as the other one. SHIFT0 does the same shifts with a 0 entering the quotient. Because both branches take two cycles, the latency never depends on the data.

The internal remainder register is WIDTH+1 bits wide. The extra final shift puts one bit too many into it, so the reported remainder leaves out its least significant bit.

The states are IDLE, LOAD, SUBTRACT, NOP, SHIFT0 and SHIFT1. The transitions are:
- IDLE→LOAD on start.
- LOAD→SUBTRACT when the cleared remainder fits the denominator, which happens only when the denominator is zero; otherwise LOAD→NOP.
- SUBTRACT→SHIFT1 and NOP→SHIFT0, always.
- SHIFT0 or SHIFT1→IDLE after the iteration whose index is WIDTH.
- SHIFT0 or SHIFT1→SUBTRACT or NOP otherwise, chosen by comparing the shifted remainder with the denominator.

Top module: `restoring_divider`

## Requirements
- R1: During and right after reset, `ready` is 1 and both `quotient` and `remainder` are 0.
- R2: When `start` is sampled high at a clock edge while `ready` is 1, `ready` is 0 from that edge on.
- R3: When the denominator is not zero, the finished `quotient` equals the integer quotient of the operands sampled with the accepted `start`.
- R4: When the denominator is not zero, the finished `remainder` equals the numerator modulo the denominator.
- R5: `ready` goes back to 1 exactly 2·WIDTH+3 clock edges after the edge that accepted `start`, for every pair of operands. Every SUBTRACT state is followed by SHIFT1 and every NOP state by SHIFT0.
- R6: When the denominator is zero, the finished `quotient` is all ones and the finished `remainder` equals the numerator.
- R7: While `ready` is 0, changes on `numer` and `denom` and extra `start` pulses have no effect: the running result, its timing and the idle state that follows it are unchanged.
- R8: While `ready` is 1 and `start` is low, `quotient` and `remainder` keep their values whatever `numer` and `denom` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a division |
| numer | input | WIDTH | Unsigned numerator, sampled with an accepted start |
| denom | input | WIDTH | Unsigned denominator, sampled with an accepted start |
| quotient | output | WIDTH | Quotient, valid while ready is 1 |
| remainder | output | WIDTH | Remainder, valid while ready is 1 |
| ready | output | 1 | High in IDLE: results valid, new start accepted |

## Verification
The bench drives `start` half a cycle before the edge that accepts it and samples outputs on falling edges. `ready` must already be 0 at the first falling edge after that accepting edge. It must still be 0 at the falling edge after edge 2·WIDTH+2, and it must be 1 with the results at the falling edge after edge 2·WIDTH+3. The bench counts edges to exactly those sample points, so a result that arrives one cycle early or late is reported. Expected values come from integer division in the bench: all 256 operand pairs are tried at width 4, and pseudo-random pairs plus zero denominators at width 8. Hold and ignore behaviour is checked by changing the inputs during idle and busy windows and sampling the outputs over several following cycles.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SUBTRACT,
        ST_NOP,
        ST_SHIFT0,
        ST_SHIFT1
    } rdiv_state_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CAPTURE,
        OP_LOAD,
        OP_SUB,
        OP_SHIFT0,
        OP_SHIFT1
    } rdiv_op_e;

    // Edges from the accepting edge until ready is high again.
    function automatic int unsigned rdiv_latency(input int unsigned width);
        return 2 * width + 3;
    endfunction

endpackage

// File: rtl/rdiv_iter_cnt.sv
module rdiv_iter_cnt #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(WIDTH + 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The iteration with index WIDTH is the final one.
    assign last = (cnt_q == CW'(WIDTH));

endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  rdiv_op_e         op,
    input  logic [WIDTH-1:0] num_in,
    input  logic [WIDTH-1:0] den_in,
    output logic [WIDTH-1:0] num_q,
    output logic [WIDTH-1:0] den_q,
    output logic [WIDTH-1:0] quot_q,
    output logic [WIDTH:0]   rem_q,
    output logic             fits
);
    localparam int RW = WIDTH + 1;

    logic [RW-1:0]    rem_d;
    logic [WIDTH-1:0] quot_d;
    logic [RW-1:0]    den_ext;
    logic [RW-1:0]    rem_shifted;

    assign den_ext     = {1'b0, den_q};
    assign rem_shifted = {rem_q[WIDTH-1:0], quot_q[WIDTH-1]};

    always_comb begin
        rem_d  = rem_q;
        quot_d = quot_q;
        unique case (op)
            OP_HOLD, OP_CAPTURE: begin
                rem_d  = rem_q;
                quot_d = quot_q;
            end
            OP_LOAD: begin
                rem_d  = '0;
                quot_d = num_q;
            end
            OP_SUB: begin
                rem_d = rem_q - den_ext;
            end
            OP_SHIFT0: begin
                rem_d  = rem_shifted;
                quot_d = {quot_q[WIDTH-2:0], 1'b0};
            end
            OP_SHIFT1: begin
                rem_d  = rem_shifted;
                quot_d = {quot_q[WIDTH-2:0], 1'b1};
            end
            default: begin
                rem_d  = rem_q;
                quot_d = quot_q;
            end
        endcase
    end

    // Compare the value the remainder register is about to take, so the
    // branch for the next iteration is chosen while LOAD or SHIFT is active.
    assign fits = (rem_d >= den_ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q  <= '0;
            den_q  <= '0;
            quot_q <= '0;
            rem_q  <= '0;
        end else begin
            if (op == OP_CAPTURE) begin
                num_q <= num_in;
                den_q <= den_in;
            end
            quot_q <= quot_d;
            rem_q  <= rem_d;
        end
    end

endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
    import rdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        fits,
    input  logic        last,
    output rdiv_state_e state_q,
    output rdiv_op_e    op,
    output logic        cnt_clear,
    output logic        cnt_step,
    output logic        ready
);
    rdiv_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = start ? ST_LOAD : ST_IDLE;
            ST_LOAD:     state_d = fits ? ST_SUBTRACT : ST_NOP;
            ST_SUBTRACT: state_d = ST_SHIFT1;
            ST_NOP:      state_d = ST_SHIFT0;
            ST_SHIFT0,
            ST_SHIFT1: begin
                if (last) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = fits ? ST_SUBTRACT : ST_NOP;
                end
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        op        = OP_HOLD;
        cnt_clear = 1'b0;
        cnt_step  = 1'b0;
        ready     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                op    = start ? OP_CAPTURE : OP_HOLD;
            end
            ST_LOAD: begin
                op        = OP_LOAD;
                cnt_clear = 1'b1;
            end
            ST_SUBTRACT: op = OP_SUB;
            ST_NOP:      op = OP_HOLD;
            ST_SHIFT0: begin
                op       = OP_SHIFT0;
                cnt_step = 1'b1;
            end
            ST_SHIFT1: begin
                op       = OP_SHIFT1;
                cnt_step = 1'b1;
            end
            default:     op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] numer,
    input  logic [WIDTH-1:0] denom,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             ready
);
    rdiv_state_e      state_q;
    rdiv_op_e         op;
    logic             cnt_clear;
    logic             cnt_step;
    logic             last;
    logic             fits;
    logic [WIDTH-1:0] num_q;
    logic [WIDTH-1:0] den_q;
    logic [WIDTH-1:0] quot_q;
    logic [WIDTH:0]   rem_q;

    rdiv_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .fits      (fits),
        .last      (last),
        .state_q   (state_q),
        .op        (op),
        .cnt_clear (cnt_clear),
        .cnt_step  (cnt_step),
        .ready     (ready)
    );

    rdiv_iter_cnt #(.WIDTH(WIDTH)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .step  (cnt_step),
        .last  (last)
    );

    rdiv_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .num_in (numer),
        .den_in (denom),
        .num_q  (num_q),
        .den_q  (den_q),
        .quot_q (quot_q),
        .rem_q  (rem_q),
        .fits   (fits)
    );

    assign quotient  = quot_q;
    assign remainder = rem_q[WIDTH:1];

endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             ready,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder,
    input rdiv_state_e      state_q,
    input logic [WIDTH-1:0] num_q,
    input logic [WIDTH-1:0] den_q,
    input logic [WIDTH:0]   rem_q
);
    localparam int LAT = int'(rdiv_latency(WIDTH));

    int lat_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= 0;
        end else if (ready && start) begin
            lat_cnt <= 0;
        end else if (!ready) begin
            lat_cnt <= lat_cnt + 1;
        end
    end

    p_start_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> !ready);

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUBTRACT) |-> (rem_q >= {1'b0, den_q}));

    p_quotient_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && den_q != '0) |-> (quotient == num_q / den_q));

    p_remainder_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && den_q != '0) |-> (remainder == num_q % den_q));

    p_fixed_latency_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (lat_cnt == LAT));

    p_busy_window_r5: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (lat_cnt < LAT));

    p_sub_then_shift1_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUBTRACT) |=> (state_q == ST_SHIFT1));

    p_nop_then_shift0_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NOP) |=> (state_q == ST_SHIFT0));

    p_div_zero_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && den_q == '0) |->
        (quotient == {WIDTH{1'b1}} && remainder == num_q));

    p_operands_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !ready |=> ($stable(num_q) && $stable(den_q)));

    p_results_held_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ($stable(quotient) && $stable(remainder) && ready));

endmodule

bind restoring_divider restoring_divider_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ready     (ready),
    .quotient  (quotient),
    .remainder (remainder),
    .state_q   (state_q),
    .num_q     (num_q),
    .den_q     (den_q),
    .rem_q     (rem_q)
);

// File: tb/tb_restoring_divider.sv
`timescale 1ns/1ps
module tb_restoring_divider;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic       start4 = 1'b0;
    logic [3:0] num4 = '0;
    logic [3:0] den4 = '0;
    logic [3:0] quot4;
    logic [3:0] rem4;
    logic       ready4;

    logic       start8 = 1'b0;
    logic [7:0] num8 = '0;
    logic [7:0] den8 = '0;
    logic [7:0] quot8;
    logic [7:0] rem8;
    logic       ready8;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    restoring_divider #(.WIDTH(4)) dut (
        .clk (clk), .rst (rst), .start (start4),
        .numer (num4), .denom (den4),
        .quotient (quot4), .remainder (rem4), .ready (ready4)
    );

    restoring_divider #(.WIDTH(8)) dut_w8 (
        .clk (clk), .rst (rst), .start (start8),
        .numer (num8), .denom (den8),
        .quotient (quot8), .remainder (rem8), .ready (ready8)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One division on the 4-bit unit; inputs are scrambled while busy (R7).
    task automatic run4(input int a, input int b);
        int eq;
        int er;
        eq = (b == 0) ? 15 : a / b;
        er = (b == 0) ? a : a % b;
        @(negedge clk);
        start4 = 1'b1; num4 = 4'(a); den4 = 4'(b);
        @(negedge clk);
        start4 = 1'b0; num4 = 4'(a + 5); den4 = 4'(b + 3);
        check(ready4 == 1'b0, "R2 ready low after start", int'(ready4), 0);
        repeat (2 * 4 + 2) @(negedge clk);
        check(ready4 == 1'b0, "R5 ready still low one edge before due", int'(ready4), 0);
        @(negedge clk);
        check(ready4 == 1'b1, "R5 ready due at 2N+3", int'(ready4), 1);
        if (b == 0) begin
            check(quot4 == 4'(eq), "R6 quotient all ones w4", int'(quot4), eq);
            check(rem4 == 4'(er), "R6 remainder = numerator w4", int'(rem4), er);
        end else begin
            check(quot4 == 4'(eq), "R3 quotient w4", int'(quot4), eq);
            check(rem4 == 4'(er), "R4 remainder w4", int'(rem4), er);
        end
    endtask

    task automatic run8(input int a, input int b);
        int eq;
        int er;
        eq = (b == 0) ? 255 : a / b;
        er = (b == 0) ? a : a % b;
        @(negedge clk);
        start8 = 1'b1; num8 = 8'(a); den8 = 8'(b);
        @(negedge clk);
        start8 = 1'b0; num8 = 8'(a ^ 8'h5a); den8 = 8'(b + 7);
        check(ready8 == 1'b0, "R2 ready low after start w8", int'(ready8), 0);
        repeat (2 * 8 + 2) @(negedge clk);
        check(ready8 == 1'b0, "R5 ready still low w8", int'(ready8), 0);
        @(negedge clk);
        check(ready8 == 1'b1, "R5 ready due at 2N+3 w8", int'(ready8), 1);
        if (b == 0) begin
            check(quot8 == 8'(eq), "R6 quotient all ones w8", int'(quot8), eq);
            check(rem8 == 8'(er), "R6 remainder = numerator w8", int'(rem8), er);
        end else begin
            check(quot8 == 8'(eq), "R3 quotient w8", int'(quot8), eq);
            check(rem8 == 8'(er), "R4 remainder w8", int'(rem8), er);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ready4 == 1'b1 && quot4 == 4'd0 && rem4 == 4'd0, "R1 reset state w4",
              int'({ready4, quot4, rem4}), 256);
        check(ready8 == 1'b1 && quot8 == 8'd0 && rem8 == 8'd0, "R1 reset state w8",
              int'({ready8, quot8, rem8}), 65536);
        rst = 1'b0;
        @(negedge clk);
        check(ready4 == 1'b1 && quot4 == 4'd0 && rem4 == 4'd0, "R1 state after release",
              int'({ready4, quot4, rem4}), 256);

        // Exhaustive sweep at width 4 (R3, R4, R5, R6)
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run4(a, b);
            end
        end

        // R8: results held while idle with moving inputs
        run4(14, 4);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            num4 = 4'(k * 3); den4 = 4'(k + 1);
            check(quot4 == 4'd3 && rem4 == 4'd2 && ready4, "R8 results held",
                  int'({quot4, rem4}), 50);
        end

        // R7: extra start pulse while busy is ignored
        @(negedge clk);
        start4 = 1'b1; num4 = 4'd13; den4 = 4'd3;
        @(negedge clk);
        start4 = 1'b0;
        repeat (2) @(negedge clk);
        start4 = 1'b1; num4 = 4'd2; den4 = 4'd1;
        @(negedge clk);
        start4 = 1'b0;
        check(ready4 == 1'b0, "R7 busy despite extra start", int'(ready4), 0);
        repeat (2 * 4 + 2 - 3) @(negedge clk);
        check(ready4 == 1'b0, "R7 timing unchanged (still busy)", int'(ready4), 0);
        @(negedge clk);
        check(ready4 == 1'b1, "R7 timing unchanged (done)", int'(ready4), 1);
        check(quot4 == 4'd4 && rem4 == 4'd1, "R7 result of first operands",
              int'({quot4, rem4}), 65);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(ready4 == 1'b1 && quot4 == 4'd4 && rem4 == 4'd1,
                  "R7 no second run started", int'({ready4, quot4, rem4}), 321);
        end

        // Width 8: corners and pseudo-random pairs
        run8(255, 1);
        run8(255, 255);
        run8(0, 7);
        run8(200, 0);
        run8(0, 0);
        run8(128, 3);
        for (int k = 0; k < 300; k++) begin
            run8(int'($urandom_range(255)), int'($urandom_range(255)));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule